// File: doc/BRIEF.md
# JTAG User-Register Byte Stream Bridge

This block moves bytes in both directions between a JTAG host and on-chip logic through one user data register of the TAP. The TAP controller outside the block decodes the user instruction and hands over test clock, serial data and the capture, shift and update strobes. On the fabric side there are two valid/ready byte streams. The outgoing stream carries bytes from the fabric toward the host. The incoming stream carries bytes from the host into the fabric.

Each data-register scan carries one 10-bit frame. Bit 0 is a valid flag. Bits 8..1 hold a byte, least significant bit at bit 1, so it leaves the chip first. Bit 9 is a ready flag. On the way out, the frame is loaded into the shift register at capture. On the way in, it is taken from the shift register at update.

The frame is never decoded by counting shift cycles. The bridge therefore keeps working when other TAPs in the chain add extra shift cycles to a scan. Capture and update events reach the fabric clock through toggle synchronizers with edge detection.

Top module: `jtag_stream_bridge`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0 and `tdo` is 0.
- R2: A selected capture loads the register with bit 0 = 1 exactly when an outgoing byte is held, bits 8..1 = that byte (bit 1 = LSB), and bit 9 = 1 exactly when no incoming byte is waiting in the bridge.
- R3: While selected, each shift clock moves `tdi` into bit 9 and the register right by one, and `tdo` always shows bit 0. After a scan of 10 or more shift cycles, the register holds the last 10 bits shifted in.
- R4: At a selected update where bit 0 is 1 and the preceding capture reported bit 9 = 1, bits 8..1 appear on `rx_data` with `rx_valid` = 1.
- R5: At update, a host byte sent while the preceding capture reported bit 9 = 0 is dropped, and the waiting incoming byte is unchanged.
- R6: When the preceding capture reported bit 0 = 1, the update releases the held outgoing byte. `tx_ready` returns to 1, and the next capture reports bit 0 = 0.
- R7: Between a capture and its update, `tx_ready` is 0, so no outgoing byte is accepted mid-scan.
- R8: An incoming byte holds `rx_valid` and `rx_data` steady until `rx_ready` is 1 on a clock edge. It is then cleared, and the next capture reports bit 9 = 1.
- R9: With `tap_sel` low, capture, shift and update strobes have no effect: no byte is pushed, none is released, and `tdo` does not change.
- R10: A byte is taken on `tx_data` at a clock edge where `tx_valid` and `tx_ready` are both 1. That byte is the one reported by the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| tck | input | 1 | JTAG test clock |
| tdi | input | 1 | Serial data from host |
| tdo | output | 1 | Serial data to host, bit 0 of the register |
| tap_sel | input | 1 | The user instruction for this register is active |
| tap_capture | input | 1 | Capture-DR strobe, sampled on rising `tck` |
| tap_shift | input | 1 | Shift-DR strobe, sampled on rising `tck` |
| tap_update | input | 1 | Update-DR strobe, sampled on rising `tck` |
| tx_valid | input | 1 | Outgoing byte offered by fabric |
| tx_ready | output | 1 | Bridge accepts an outgoing byte |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Incoming byte available |
| rx_ready | input | 1 | Fabric takes the incoming byte |
| rx_data | output | 8 | Incoming byte |

## Verification
The assertions assume that the capture, shift and update strobes never overlap and that every update follows a capture. They also assume `tck` is slow enough that each event has crossed into the fabric clock before the next one arrives. Under these assumptions, a push can only reach an empty incoming slot, and the outgoing slot is cleared only by a pop event. The bench drives `tck` by hand at ten fabric clocks per period and raises one strobe at a time. After every update it waits several fabric clocks, so each event has settled before the next scan starts.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  parameter int unsigned JSB_DATA_W = 8;
  localparam int unsigned JSB_FRAME_W = JSB_DATA_W + 2;
  localparam int unsigned JSB_RDY_BIT = JSB_FRAME_W - 1;

  typedef logic [JSB_FRAME_W-1:0] jsb_frame_t;
  typedef logic [JSB_DATA_W-1:0]  jsb_byte_t;

  // frame layout: [ready | byte | valid]
  function automatic jsb_frame_t jsb_pack(input logic rdy, input jsb_byte_t b, input logic vld);
    return {rdy, b, vld};
  endfunction

  function automatic jsb_byte_t jsb_byte(input jsb_frame_t f);
    return f[JSB_FRAME_W-2:1];
  endfunction

  function automatic logic jsb_valid(input jsb_frame_t f);
    return f[0];
  endfunction
endpackage

// File: rtl/jsb_evsync.sv
module jsb_evsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], tgl_in};
      last  <= chain[STAGES-1];
    end
  end

  assign pulse = chain[STAGES-1] ^ last;
endmodule

// File: rtl/jsb_tck_side.sv
module jsb_tck_side
  import jsb_pkg::*;
(
  input  logic      tck,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      capture,
  input  logic      shift,
  input  logic      update,
  input  logic      tdi,
  output logic      tdo,
  input  logic      tx_full,
  input  jsb_byte_t tx_hold,
  input  logic      rx_full,
  output logic      cap_tgl,
  output logic      upd_tgl,
  output logic      upd_push,
  output logic      upd_pop,
  output jsb_byte_t upd_data
);
  jsb_frame_t sreg;
  logic       cap_valid;
  logic       cap_accept;

  wire do_cap = sel & capture;
  wire do_sh  = sel & shift;
  wire do_upd = sel & update;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sreg       <= '0;
      cap_valid  <= 1'b0;
      cap_accept <= 1'b0;
      cap_tgl    <= 1'b0;
    end else if (do_cap) begin
      sreg       <= jsb_pack(!rx_full, tx_hold, tx_full);
      cap_valid  <= tx_full;
      cap_accept <= !rx_full;
      cap_tgl    <= !cap_tgl;
    end else if (do_sh) begin
      sreg <= {tdi, sreg[JSB_FRAME_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_push <= 1'b0;
      upd_pop  <= 1'b0;
      upd_data <= '0;
      upd_tgl  <= 1'b0;
    end else if (do_upd) begin
      upd_push <= jsb_valid(sreg) & cap_accept;
      upd_pop  <= cap_valid;
      upd_data <= jsb_byte(sreg);
      upd_tgl  <= !upd_tgl;
    end
  end

  assign tdo = sreg[0];
endmodule

// File: rtl/jsb_fabric.sv
module jsb_fabric
  import jsb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cap_ev,
  input  logic      upd_ev,
  input  logic      upd_push,
  input  logic      upd_pop,
  input  jsb_byte_t upd_data,
  input  logic      tx_valid,
  output logic      tx_ready,
  input  jsb_byte_t tx_data,
  output logic      rx_valid,
  input  logic      rx_ready,
  output jsb_byte_t rx_data,
  output logic      tx_full,
  output jsb_byte_t tx_hold,
  output logic      rx_full,
  output logic      scan_busy
);
  wire tx_take = tx_valid & tx_ready;
  wire rx_give = rx_full & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_busy <= 1'b0;
    else if (cap_ev) scan_busy <= 1'b1;
    else if (upd_ev) scan_busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (upd_ev && upd_pop) begin
      tx_full <= 1'b0;
    end else if (tx_take) begin
      tx_full <= 1'b1;
      tx_hold <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_data <= '0;
    end else if (upd_ev && upd_push && !rx_full) begin
      rx_full <= 1'b1;
      rx_data <= upd_data;
    end else if (rx_give) begin
      rx_full <= 1'b0;
    end
  end

  assign tx_ready = !tx_full && !scan_busy;
  assign rx_valid = rx_full;
endmodule

// File: rtl/jtag_stream_bridge.sv
module jtag_stream_bridge
  import jsb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tck,
  input  logic                  tdi,
  output logic                  tdo,
  input  logic                  tap_sel,
  input  logic                  tap_capture,
  input  logic                  tap_shift,
  input  logic                  tap_update,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [JSB_DATA_W-1:0] tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [JSB_DATA_W-1:0] rx_data
);
  logic      cap_tgl, upd_tgl;
  logic      cap_ev, upd_ev;
  logic      upd_push, upd_pop;
  jsb_byte_t upd_data;
  logic      tx_full, rx_full, scan_busy;
  jsb_byte_t tx_hold;

  jsb_tck_side i_tck (
    .tck(tck), .rst_n(rst_n), .sel(tap_sel), .capture(tap_capture),
    .shift(tap_shift), .update(tap_update), .tdi(tdi), .tdo(tdo),
    .tx_full(tx_full), .tx_hold(tx_hold), .rx_full(rx_full),
    .cap_tgl(cap_tgl), .upd_tgl(upd_tgl), .upd_push(upd_push),
    .upd_pop(upd_pop), .upd_data(upd_data)
  );

  jsb_evsync #(.STAGES(SYNC_STAGES)) i_cap_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(cap_tgl), .pulse(cap_ev)
  );

  jsb_evsync #(.STAGES(SYNC_STAGES)) i_upd_sync (
    .clk(clk), .rst_n(rst_n), .tgl_in(upd_tgl), .pulse(upd_ev)
  );

  jsb_fabric i_fab (
    .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev), .upd_ev(upd_ev),
    .upd_push(upd_push), .upd_pop(upd_pop), .upd_data(upd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_full(tx_full), .tx_hold(tx_hold), .rx_full(rx_full),
    .scan_busy(scan_busy)
  );
endmodule

// File: rtl/jsb_checker.sv
module jsb_checker
  import jsb_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cap_ev,
  input logic      upd_ev,
  input logic      upd_push,
  input logic      upd_pop,
  input logic      scan_busy,
  input logic      tx_full,
  input logic      tx_ready,
  input logic      rx_valid,
  input logic      rx_ready,
  input jsb_byte_t rx_data
);
  p_busy_blocks_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> !tx_ready);

  p_rx_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_push_into_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ev && upd_push) |-> !rx_valid);

  p_rx_rise_on_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(upd_ev && upd_push));

  p_tx_clear_on_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> $past(upd_ev && upd_pop));

  p_events_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_ev && upd_ev));
endmodule

bind jtag_stream_bridge jsb_checker i_jsb_checker (
  .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev), .upd_ev(upd_ev),
  .upd_push(upd_push), .upd_pop(upd_pop), .scan_busy(scan_busy),
  .tx_full(tx_full), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/test_jtag_stream_bridge.sv
`timescale 1ns/1ps
module test_jtag_stream_bridge;
  logic clk = 0, rst_n = 0, tck = 0, tdi = 0;
  logic tap_sel = 0, tap_capture = 0, tap_shift = 0, tap_update = 0;
  logic tx_valid = 0, rx_ready = 0;
  logic [7:0] tx_data = 0;
  logic tdo, tx_ready, rx_valid;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0;
  logic done = 0;

  always #2 clk = ~clk;

  jtag_stream_bridge i_jtag_stream_bridge (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tdi(tdi), .tdo(tdo),
    .tap_sel(tap_sel), .tap_capture(tap_capture), .tap_shift(tap_shift),
    .tap_update(tap_update), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data)
  );

  task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] frm(input logic rdy, input logic [7:0] b, input logic vld);
    return {rdy, b, vld};
  endfunction

  task automatic tck_pulse();
    #20 tck = 1;
    #20 tck = 0;
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic do_capture();
    tap_capture = 1; tck_pulse(); tap_capture = 0;
  endtask

  task automatic do_shift(input logic [9:0] f, input int extra, output logic [9:0] seen);
    seen = '0;
    tap_shift = 1;
    for (int j = 0; j < 10 + extra; j++) begin
      if (j < 10) seen[j] = tdo;
      tdi = (j < extra) ? j[0] : f[j - extra];
      tck_pulse();
    end
    tap_shift = 0;
  endtask

  task automatic do_update();
    tap_update = 1; tck_pulse(); tap_update = 0;
    settle();
  endtask

  task automatic scan(input logic [9:0] f, input int extra, output logic [9:0] seen);
    do_capture();
    do_shift(f, extra, seen);
    do_update();
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_valid = 1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1 tx_valid = 0;
  endtask

  task automatic take_rx();
    @(negedge clk); rx_ready = 1;
    @(posedge clk); #1 rx_ready = 0;
    settle();
  endtask

  task automatic t_reset();
    check(tx_ready == 1, "R1 tx_ready", 16'(tx_ready), 1);
    check(rx_valid == 0, "R1 rx_valid", 16'(rx_valid), 0);
    check(tdo == 0, "R1 tdo", 16'(tdo), 0);
  endtask

  task automatic t_empty();
    logic [9:0] s;
    scan(frm(0, 8'h00, 0), 0, s);
    check(s == frm(1, 8'h00, 0), "R2 empty capture", 16'(s), 16'(frm(1, 8'h00, 0)));
    check(rx_valid == 0, "R4 no push on valid=0", 16'(rx_valid), 0);
  endtask

  task automatic t_tx_one();
    logic [9:0] s;
    send_tx(8'hA5);
    check(tx_ready == 0, "R10 byte taken", 16'(tx_ready), 0);
    scan(frm(0, 8'h00, 0), 0, s);
    check(s == frm(1, 8'hA5, 1), "R2 R10 captured byte", 16'(s), 16'(frm(1, 8'hA5, 1)));
    check(tx_ready == 1, "R6 released", 16'(tx_ready), 1);
    scan(frm(0, 8'h00, 0), 0, s);
    check(s[0] == 0, "R6 next valid=0", 16'(s), 16'(frm(1, 8'h00, 0)));
  endtask

  task automatic t_rx_push();
    logic [9:0] s;
    scan(frm(0, 8'h3C, 1), 3, s);
    check(rx_valid == 1, "R4 R3 rx_valid extra shifts", 16'(rx_valid), 1);
    check(rx_data == 8'h3C, "R4 R3 rx_data", 16'(rx_data), 16'h3C);
  endtask

  task automatic t_rx_full();
    logic [9:0] s;
    scan(frm(0, 8'h77, 1), 0, s);
    check(s[9] == 0, "R2 R8 full shows bit9=0", 16'(s), 16'(frm(0, 8'h00, 0)));
    check(rx_data == 8'h3C && rx_valid, "R5 dropped byte", 16'(rx_data), 16'h3C);
    take_rx();
    check(rx_valid == 0, "R8 consumed", 16'(rx_valid), 0);
    scan(frm(0, 8'h00, 0), 0, s);
    check(s[9] == 1, "R8 bit9 back", 16'(s), 16'(frm(1, 8'h00, 0)));
  endtask

  task automatic t_busy();
    logic [9:0] s;
    do_capture();
    settle();
    check(tx_ready == 0, "R7 busy mid-scan", 16'(tx_ready), 0);
    do_shift(frm(0, 8'h00, 0), 0, s);
    check(tx_ready == 0, "R7 busy after shift", 16'(tx_ready), 0);
    do_update();
    check(tx_ready == 1, "R7 free after update", 16'(tx_ready), 1);
  endtask

  task automatic t_desel();
    logic [9:0] s;
    logic t0;
    send_tx(8'h69);
    tap_sel = 0;
    t0 = tdo;
    scan(frm(0, 8'h11, 1), 0, s);
    check(rx_valid == 0, "R9 no push deselected", 16'(rx_valid), 0);
    check(tx_ready == 0, "R9 no pop deselected", 16'(tx_ready), 0);
    check(tdo == t0, "R9 tdo unchanged", 16'(tdo), 16'(t0));
    tap_sel = 1;
    scan(frm(0, 8'h00, 0), 0, s);
    check(s == frm(1, 8'h69, 1), "R9 R2 held byte after reselect", 16'(s), 16'(frm(1, 8'h69, 1)));
  endtask

  task automatic t_duplex();
    logic [9:0] s;
    send_tx(8'h5A);
    scan(frm(1, 8'hC3, 1), 5, s);
    check(s == frm(1, 8'h5A, 1), "R3 duplex capture", 16'(s), 16'(frm(1, 8'h5A, 1)));
    check(rx_valid && rx_data == 8'hC3, "R3 R4 duplex push", 16'(rx_data), 16'hC3);
    check(tx_ready == 1, "R6 duplex pop", 16'(tx_ready), 1);
    take_rx();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    t_reset();
    tap_sel = 1;
    t_empty();
    t_tx_one();
    t_rx_push();
    t_rx_full();
    t_busy();
    t_desel();
    t_duplex();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule